// File: doc/BRIEF.md
# Page-Mode Read Sequencer

This block runs asynchronous reads against an external memory that offers a fast in-page access mode. It remembers which aligned page it touched last. Each read request is either the opening access to a page or a follow-up inside the page already open. The block picks the matching programmed access length and holds chip-select and read-strobe low for exactly that many clock cycles. It samples the returned word on the final cycle and presents it with a one-cycle valid pulse.

Software-side configuration arrives as plain inputs: an enable for page operation, a two-bit page-size code, a flag selecting a 16-bit device, and two 7-bit access lengths (one for the opening access, one for in-page accesses). A simple valid/ready handshake carries the 24-bit byte address. A request held on the last cycle of an access starts the next access right away, without releasing chip-select.

Top module: `page_read_ctl`

## Requirements
- R1: While reset is asserted and after its release, mem_cs_n and mem_rd_n are high, req_ready is high, rd_valid is low, and no page is considered open.
- R2: When pg_en is 0, every read uses the opening-access length.
- R3: pg_size codes 0, 1, 2, 3 select pages of 4, 8, 16, 32 bytes aligned to their size; a read whose address bits above the page boundary equal the open page's uses the in-page length.
- R4: A read to any page other than the open one uses the opening-access length, and its page becomes the open page.
- R5: Changing pg_size or dev16, or clearing pg_en, closes the open page, so the next read uses the opening-access length.
- R6: When dev16 is 1, mem_addr[0] is driven 0 and the returned data belongs to that even address.
- R7: mem_cs_n and mem_rd_n are low for exactly the effective access length of each read, and mem_addr holds steady while the access runs.
- R8: mem_rdata is sampled on the last access cycle; rd_valid is high for the following cycle with rd_data holding the sampled word.
- R9: A length field of 0 counts as 1 cycle and a value above 64 counts as 64 cycles.
- R10: req_ready is low during an access except on its last cycle; a request present on that cycle starts the next access with mem_cs_n kept low, otherwise mem_cs_n returns high.
- R11: An access starts only on a cycle where req_valid and req_ready were both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 24 | Byte address of the read |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| pg_en | input | 1 | Enable in-page fast accesses |
| pg_size | input | 2 | Page size code: 0=4, 1=8, 2=16, 3=32 bytes |
| dev16 | input | 1 | 1 selects a 16-bit device (address bit 0 ignored) |
| first_len | input | 7 | Cycles for the opening access of a page |
| next_len | input | 7 | Cycles for a follow-up access inside the page |
| mem_addr | output | 24 | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_rdata | input | 16 | Data returned by the memory |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data fresh |

## Verification
A wrong open-page flag or stored page tag appears at the ports as a read whose strobe width is the other programmed length, visible on the very next read after the fault. The bench therefore programs two clearly different lengths and counts strobe cycles for every read, so a missed hit, a false hit, or a page left open across a configuration change is caught within one access. A counter or capture fault shows as a wrong strobe count or a data word that does not match the memory model at the driven address, reported when rd_valid pulses.

// File: rtl/page_read_pkg.sv
`timescale 1ns/1ps
package page_read_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

  // Number of in-page offset bits for a page-size code.
  function automatic logic [2:0] offset_bits(input logic [1:0] size_code);
    return 3'd2 + {1'b0, size_code};
  endfunction
endpackage

// File: rtl/page_tracker.sv
`timescale 1ns/1ps
module page_tracker #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              pg_en,
  input  logic [1:0]        pg_size,
  input  logic              dev16,
  output logic              hit
);
  import page_read_pkg::*;

  logic              open_q, open_d;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [1:0]        size_q;
  logic              dev16_q;
  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] page_of_req;
  logic              cfg_moved;
  logic [2:0]        shift;

  assign shift = offset_bits(pg_size);

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      keep[i] = (i >= int'(shift));
    end
  end

  assign page_of_req = req_addr & keep;
  assign cfg_moved   = (pg_size != size_q) || (dev16 != dev16_q);
  assign hit         = open_q && pg_en && !cfg_moved && (page_of_req == tag_q);

  always_comb begin
    open_d = open_q;
    tag_d  = tag_q;
    if (!pg_en || cfg_moved) begin
      open_d = 1'b0;
    end
    if (accept && pg_en) begin
      open_d = 1'b1;
      tag_d  = page_of_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      tag_q   <= '0;
      size_q  <= '0;
      dev16_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      tag_q   <= tag_d;
      size_q  <= pg_size;
      dev16_q <= dev16;
    end
  end
endmodule

// File: rtl/access_timer.sv
`timescale 1ns/1ps
module access_timer #(
  parameter int ADDR_W  = 24,
  parameter int LEN_W   = 7,
  parameter int MAX_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              dev16,
  input  logic              hit,
  input  logic [LEN_W-1:0]  first_len,
  input  logic [LEN_W-1:0]  next_len,
  output logic              req_ready,
  output logic              accept,
  output logic              last,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n
);
  import page_read_pkg::*;

  localparam int CNT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  picked;
  logic [LEN_W-1:0]  eff_len;
  logic [ADDR_W-1:0] drive_addr;
  logic              busy;

  assign picked = hit ? next_len : first_len;

  always_comb begin
    if (picked == '0) begin
      eff_len = LEN_W'(1);
    end else if (picked > LEN_W'(MAX_LEN)) begin
      eff_len = LEN_W'(MAX_LEN);
    end else begin
      eff_len = picked;
    end
  end

  always_comb begin
    drive_addr = req_addr;
    if (dev16) begin
      drive_addr[0] = 1'b0;
    end
  end

  assign busy      = (state_q == SEQ_BUSY);
  assign last      = busy && (cnt_q == '0);
  assign req_ready = !busy || last;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    if (accept) begin
      state_d = SEQ_BUSY;
      cnt_d   = CNT_W'(eff_len - LEN_W'(1));
      addr_d  = drive_addr;
    end else if (last) begin
      state_d = SEQ_IDLE;
    end else if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
    end
  end

  assign mem_addr = addr_q;
  assign mem_cs_n = !busy;
  assign mem_rd_n = !busy;
endmodule

// File: rtl/data_capture.sv
`timescale 1ns/1ps
module data_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (last) begin
      data_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= last;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/page_read_ctl.sv
`timescale 1ns/1ps
module page_read_ctl #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 7,
  parameter int MAX_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              pg_en,
  input  logic [1:0]        pg_size,
  input  logic              dev16,
  input  logic [LEN_W-1:0]  first_len,
  input  logic [LEN_W-1:0]  next_len,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic hit;
  logic accept;
  logic last;

  page_tracker #(.ADDR_W(ADDR_W)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .req_addr (req_addr),
    .pg_en    (pg_en),
    .pg_size  (pg_size),
    .dev16    (dev16),
    .hit      (hit)
  );

  access_timer #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .dev16     (dev16),
    .hit       (hit),
    .first_len (first_len),
    .next_len  (next_len),
    .req_ready (req_ready),
    .accept    (accept),
    .last      (last),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n)
  );

  data_capture #(.DATA_W(DATA_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .last      (last),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/page_read_ctl_chk.sv
`timescale 1ns/1ps
module page_read_ctl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              dev16,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_rd_n,
  input logic              rd_valid
);
  // R8
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_rd_n));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !req_ready) |=> $stable(mem_addr));

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> req_ready);

  // R6
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && dev16 && $stable(dev16)) |-> (mem_addr[0] == 1'b0));

  // R11
  start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> $past(req_valid && req_ready));

  // R7
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> mem_rd_n);
endmodule

bind page_read_ctl page_read_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dev16     (dev16),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_rd_n  (mem_rd_n),
  .rd_valid  (rd_valid)
);

// File: tb/page_read_ctl_test.sv
`timescale 1ns/1ps
module page_read_ctl_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        req_ready;
  logic        pg_en;
  logic [1:0]  pg_size;
  logic        dev16;
  logic [6:0]  first_len;
  logic [6:0]  next_len;
  logic [23:0] mem_addr;
  logic        mem_cs_n;
  logic        mem_rd_n;
  logic [15:0] mem_rdata;
  logic [15:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  page_read_ctl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .pg_en     (pg_en),
    .pg_size   (pg_size),
    .dev16     (dev16),
    .first_len (first_len),
    .next_len  (next_len),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] mem_model(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
  endfunction

  assign mem_rdata = mem_model(mem_addr);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // fields: addr, pg_en, pg_size, dev16, first_len, next_len, expected cycles
  localparam int NV = 17;
  localparam logic [48:0] VECS [0:NV-1] = '{
    {24'h000100, 1'b1, 2'd0, 1'b0, 7'd5,   7'd2,  7'd5},  // R4 first page
    {24'h000102, 1'b1, 2'd0, 1'b0, 7'd5,   7'd2,  7'd2},  // R3 4-byte hit
    {24'h000104, 1'b1, 2'd0, 1'b0, 7'd5,   7'd2,  7'd5},  // R4 next 4-byte page
    {24'h000108, 1'b1, 2'd3, 1'b0, 7'd5,   7'd2,  7'd5},  // R5 size change
    {24'h00011F, 1'b1, 2'd3, 1'b0, 7'd5,   7'd2,  7'd2},  // R3 32-byte hit
    {24'h000120, 1'b1, 2'd3, 1'b0, 7'd5,   7'd2,  7'd5},  // R4 new 32-byte page
    {24'h000121, 1'b0, 2'd3, 1'b0, 7'd5,   7'd2,  7'd5},  // R2 page mode off
    {24'h000122, 1'b1, 2'd3, 1'b0, 7'd5,   7'd2,  7'd5},  // R5 closed by disable
    {24'h000123, 1'b1, 2'd3, 1'b0, 7'd5,   7'd2,  7'd2},  // R3 reopened page hit
    {24'h000125, 1'b1, 2'd3, 1'b1, 7'd5,   7'd2,  7'd5},  // R5 R6 width change
    {24'h000127, 1'b1, 2'd3, 1'b1, 7'd5,   7'd2,  7'd2},  // R6 hit, even address
    {24'h000200, 1'b1, 2'd1, 1'b1, 7'd0,   7'd0,  7'd1},  // R9 zero first length
    {24'h000201, 1'b1, 2'd1, 1'b1, 7'd0,   7'd0,  7'd1},  // R9 zero next length
    {24'h000300, 1'b1, 2'd1, 1'b1, 7'd100, 7'd0,  7'd64}, // R9 first clamp
    {24'h000302, 1'b1, 2'd1, 1'b1, 7'd100, 7'd70, 7'd64}, // R9 next clamp
    {24'h0002FF, 1'b1, 2'd2, 1'b1, 7'd3,   7'd1,  7'd3},  // R5 16-byte size
    {24'h0002F0, 1'b1, 2'd2, 1'b1, 7'd3,   7'd1,  7'd1}   // R3 16-byte hit
  };

  // One read: R7 length, R8 data, R6 address, R10 release.
  task automatic do_read(input logic [23:0] a, input int exp_len, input string tag);
    logic [23:0] exp_a;
    int n;
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    exp_a = dev16 ? {a[23:1], 1'b0} : a;
    check(mem_addr == exp_a, {tag, " R6 address"}, int'(mem_addr), int'(exp_a));
    n = 0;
    guard = 0;
    while (!rd_valid && guard < 300) begin
      if (!mem_rd_n) n++;
      @(negedge clk);
      guard++;
    end
    check(n == exp_len, {tag, " R7 length"}, n, exp_len);
    check(rd_data == mem_model(exp_a), {tag, " R8 data"}, int'(rd_data), int'(mem_model(exp_a)));
    check(mem_cs_n == 1'b1, {tag, " R10 release"}, int'(mem_cs_n), 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    pg_en     = 1'b1;
    pg_size   = 2'd0;
    dev16     = 1'b0;
    first_len = 7'd5;
    next_len  = 7'd2;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_cs_n == 1'b1 && mem_rd_n == 1'b1, "R1 strobes", int'({mem_cs_n, mem_rd_n}), 3);
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      pg_en     = VECS[i][24];
      pg_size   = VECS[i][23:22];
      dev16     = VECS[i][21];
      first_len = VECS[i][20:14];
      next_len  = VECS[i][13:7];
      do_read(VECS[i][48:25], int'(VECS[i][6:0]), $sformatf("vec%0d", i));
    end

    // R10 R11 back-to-back in-page reads keep chip select low
    pg_en = 1'b1; pg_size = 2'd3; dev16 = 1'b0; first_len = 7'd4; next_len = 7'd3;
    do_read(24'h000400, 4, "b2b open R4");
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 24'h000404;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i == 0) req_addr = 24'h000408;
      if (i == 3) req_valid = 1'b0;
      if (i < 6) begin
        check(mem_cs_n == 1'b0, "R10 cs held", int'(mem_cs_n), 0);
        check(req_ready == (i == 2 || i == 5), "R10 ready", int'(req_ready), int'(i == 2 || i == 5));
      end
      if (i == 0) check(mem_addr == 24'h000404, "R11 first addr", int'(mem_addr), 24'h404);
      if (i == 3) begin
        check(mem_addr == 24'h000408, "R11 second addr", int'(mem_addr), 24'h408);
        check(rd_valid == 1'b1 && rd_data == mem_model(24'h000404), "R8 first data",
              int'(rd_data), int'(mem_model(24'h000404)));
      end
      if (i == 4) check(rd_valid == 1'b0, "R8 pulse width", int'(rd_valid), 0);
      if (i == 6) begin
        check(mem_cs_n == 1'b1, "R10 cs release", int'(mem_cs_n), 1);
        check(rd_valid == 1'b1 && rd_data == mem_model(24'h000408), "R8 second data",
              int'(rd_data), int'(mem_model(24'h000408)));
      end
    end

    // R1 reset closes the open page
    do_read(24'h000500, 4, "pre-reset R4");
    do_read(24'h000502, 3, "pre-reset R3");
    rst_n = 1'b0;
    @(negedge clk);
    check(mem_cs_n == 1'b1 && req_ready == 1'b1, "R1 mid reset", int'({mem_cs_n, req_ready}), 3);
    rst_n = 1'b1;
    do_read(24'h000504, 4, "post-reset R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule